// File: doc/BRIEF.md
# Output Impedance Step Controller

This block holds the drive-strength code for a set of output drivers and keeps it tracking the code that an external comparison of the driver against a reference resistor asks for. The intended impedance is one fifth of that resistor, and the resistor may lie between 175 and 350 ohms. The comparison result arrives as a target code. The controller looks at the target once per fixed evaluation period and moves the applied code by at most one step toward it. A step is only applied in a cycle where the data outputs are already high-impedance, so a driving read never sees its drivers change strength.

Per-cycle indications of read, write, deselect and output-disable come from the memory's control pipeline. When a step is decided while reads keep the outputs driving, it waits and is applied at the first high-impedance cycle. A strap input tells the controller that the calibration pin is tied to a rail. In that case it parks the code at the fixed minimum-impedance value and stops tracking. A calibrated flag reports that the warm-up count of non-read cycles has been reached and the applied code matches the target.

Top module: `drv_imp_stepper`

## Requirements
- R1: After reset, `drive_code` equals RESET_CODE (default 32) and `calibrated` is 0.
- R2: An evaluation happens on every EVAL_PERIOD-th rising edge after reset (default 32: edges 32, 64, 96, ...), and only on those edges; with no strap a step can only be decided on an evaluation edge.
- R3: An evaluation compares `target_code` with `drive_code`. If the target is larger, the decided step is +1; if it is smaller, the step is -1; if they are equal, no step is decided. `drive_code` never changes by more than one per clock unless the strap is active.
- R4: A cycle is high-impedance when `wr_cycle`, `desel_cycle` or `oe_off` is 1, including a read with `oe_off` at 1. `drive_code` changes only on an edge that ends a high-impedance cycle, or while the strap is active.
- R5: A step decided on an edge whose cycle is not high-impedance is held pending and applied on the first later high-impedance edge. A later evaluation replaces the pending step and never adds a second one. If an evaluation and a high-impedance cycle fall on the same edge, the step is applied at once.
- R6: `calibrated` stays 0 until WARMUP_CYCLES (default 1024) edges with `rd_cycle` at 0 have been counted since reset. The count saturates.
- R7: `calibrated` is 1 exactly when the warm-up count is reached, `drive_code` equals `target_code`, and `strap_min_imp` is 0.
- R8: While `strap_min_imp` is 1, every edge loads `drive_code` with the minimum-impedance code (all ones when MIN_IMP_IS_MAX = 1, the default) and clears any pending step. After the strap is released, tracking resumes from that code.
- R9: `drive_code` saturates at 0 and at all ones and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_code | input | CODE_W | Code requested by the external impedance comparison |
| strap_min_imp | input | 1 | 1 = calibration pin tied to a rail; use the fixed minimum-impedance code |
| rd_cycle | input | 1 | Current cycle is a read |
| wr_cycle | input | 1 | Current cycle is a write |
| desel_cycle | input | 1 | Current cycle is deselected |
| oe_off | input | 1 | Output enable is inactive in this cycle |
| drive_code | output | CODE_W | Applied driver impedance code |
| calibrated | output | 1 | Warm-up done and applied code equals target |

## Verification
The bench targets the following corner cases, and what each fault would look like at the ports:
- **Long read bursts across several evaluations.** A design that stacks steps would jump by more than one when the burst ends. A design that ignores the hold would change strength in the middle of a read.
- **An evaluation edge that coincides with a high-impedance cycle.** An off-by-one in the cadence shows up as a step one edge late or early.
- **The warm-up boundary.** `calibrated` must rise on the 1024th non-read edge and not on any read edge.
- **Target at the top of the range, and strap entry and exit.** These expose a wrapping code, a pending step that survives the strap, and tracking that fails to restart from the minimum-impedance value.

// File: rtl/drv_imp_pkg.sv
package drv_imp_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_dir_t;
endpackage

// File: rtl/drv_imp_eval_timer.sv
module drv_imp_eval_timer #(
   parameter int PERIOD = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/drv_imp_warmup.sv
module drv_imp_warmup #(
   parameter int WARMUP = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   output logic done
);
   localparam int WW = $clog2(WARMUP + 1);
   localparam logic [WW-1:0] GOAL = WW'(WARMUP);

   logic [WW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (count_en && cnt_q != GOAL) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == GOAL);
endmodule

// File: rtl/drv_imp_step_unit.sv
module drv_imp_step_unit
   import drv_imp_pkg::*;
#(
   parameter int CODE_W         = 6,
   parameter int RESET_CODE     = 32,
   parameter bit MIN_IMP_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hiz,
   input  logic              strap,
   input  logic [CODE_W-1:0] target,
   output logic [CODE_W-1:0] code
);
   localparam logic [CODE_W-1:0] CODE_TOP = '1;
   localparam logic [CODE_W-1:0] CODE_BOT = '0;
   localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

   logic [CODE_W-1:0] min_imp_code;

   generate
      if (MIN_IMP_IS_MAX) begin : g_min_top
         assign min_imp_code = CODE_TOP;
      end else begin : g_min_bot
         assign min_imp_code = CODE_BOT;
      end
   endgenerate

   step_dir_t         pend_q, new_dir, eff_dir;
   logic [CODE_W-1:0] code_q, code_next;

   always_comb begin
      if (target > code_q)      new_dir = STEP_UP;
      else if (target < code_q) new_dir = STEP_DOWN;
      else                      new_dir = STEP_NONE;
      eff_dir = tick ? new_dir : pend_q;
      code_next = code_q;
      if (eff_dir == STEP_UP && code_q != CODE_TOP)        code_next = code_q + 1'b1;
      else if (eff_dir == STEP_DOWN && code_q != CODE_BOT) code_next = code_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_RST;
         pend_q <= STEP_NONE;
      end else if (strap) begin
         code_q <= min_imp_code;
         pend_q <= STEP_NONE;
      end else if (hiz && eff_dir != STEP_NONE) begin
         code_q <= code_next;
         pend_q <= STEP_NONE;
      end else if (tick) begin
         pend_q <= new_dir;
      end
   end

   assign code = code_q;
endmodule

// File: rtl/drv_imp_stepper.sv
module drv_imp_stepper #(
   parameter int CODE_W         = 6,
   parameter int EVAL_PERIOD    = 32,
   parameter int WARMUP_CYCLES  = 1024,
   parameter int RESET_CODE     = 32,
   parameter bit MIN_IMP_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] target_code,
   input  logic              strap_min_imp,
   input  logic              rd_cycle,
   input  logic              wr_cycle,
   input  logic              desel_cycle,
   input  logic              oe_off,
   output logic [CODE_W-1:0] drive_code,
   output logic              calibrated
);
   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("drv_imp_stepper: CODE_W must be at least 2");
      end
      if (EVAL_PERIOD < 2) begin : g_bad_period
         $error("drv_imp_stepper: EVAL_PERIOD must be at least 2");
      end
      if (WARMUP_CYCLES < 1) begin : g_bad_warm
         $error("drv_imp_stepper: WARMUP_CYCLES must be positive");
      end
      if (RESET_CODE < 0 || RESET_CODE >= (1 << CODE_W)) begin : g_bad_rst
         $error("drv_imp_stepper: RESET_CODE out of range");
      end
   endgenerate

   logic tick, warm_done, hiz;

   assign hiz = wr_cycle | desel_cycle | oe_off;

   drv_imp_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   drv_imp_warmup #(.WARMUP(WARMUP_CYCLES)) u_warm (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_en(~rd_cycle),
      .done    (warm_done)
   );

   drv_imp_step_unit #(
      .CODE_W        (CODE_W),
      .RESET_CODE    (RESET_CODE),
      .MIN_IMP_IS_MAX(MIN_IMP_IS_MAX)
   ) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .hiz   (hiz),
      .strap (strap_min_imp),
      .target(target_code),
      .code  (drive_code)
   );

   assign calibrated = warm_done && !strap_min_imp && (drive_code == target_code);
endmodule

// File: rtl/drv_imp_stepper_chk.sv
module drv_imp_stepper_chk #(
   parameter int CODE_W         = 6,
   parameter int WARMUP_CYCLES  = 1024,
   parameter bit MIN_IMP_IS_MAX = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] target_code,
   input logic              strap_min_imp,
   input logic              rd_cycle,
   input logic              wr_cycle,
   input logic              desel_cycle,
   input logic              oe_off,
   input logic [CODE_W-1:0] drive_code,
   input logic              calibrated
);
   localparam int WW = $clog2(WARMUP_CYCLES + 1);
   localparam logic [CODE_W-1:0] MIN_CODE = MIN_IMP_IS_MAX ? {CODE_W{1'b1}} : {CODE_W{1'b0}};

   logic [WW-1:0] nonrd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nonrd_q <= '0;
      else if (!rd_cycle && nonrd_q != WW'(WARMUP_CYCLES)) nonrd_q <= nonrd_q + 1'b1;
   end

   assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_min_imp |=> (drive_code == $past(drive_code)) ||
                         ({1'b0, drive_code} == {1'b0, $past(drive_code)} + 1'b1) ||
                         ({1'b0, drive_code} + 1'b1 == {1'b0, $past(drive_code)}));

   assert_hiz_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_min_imp && !(wr_cycle || desel_cycle || oe_off)) |=> drive_code == $past(drive_code));

   assert_warmup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      calibrated |-> nonrd_q == WW'(WARMUP_CYCLES));

   assert_cal_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      calibrated |-> (drive_code == target_code && !strap_min_imp));

   assert_strap_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strap_min_imp |=> drive_code == MIN_CODE);

   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_min_imp && drive_code == {CODE_W{1'b1}}) |=> drive_code != {CODE_W{1'b0}});
endmodule

bind drv_imp_stepper drv_imp_stepper_chk #(
   .CODE_W(CODE_W), .WARMUP_CYCLES(WARMUP_CYCLES), .MIN_IMP_IS_MAX(MIN_IMP_IS_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .target_code(target_code), .strap_min_imp(strap_min_imp),
   .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .desel_cycle(desel_cycle), .oe_off(oe_off),
   .drive_code(drive_code), .calibrated(calibrated)
);

// File: tb/drv_imp_stepper_tb.sv
`timescale 1ns/1ps
module drv_imp_stepper_tb;
   localparam int W = 6;
   localparam int PER = 32;
   localparam int WARM = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] target_code = 6'd32;
   logic strap_min_imp = 1'b0;
   logic rd_cycle = 1'b0, wr_cycle = 1'b0, desel_cycle = 1'b0, oe_off = 1'b0;
   logic [W-1:0] drive_code;
   logic calibrated;

   always #10 clk = ~clk;

   drv_imp_stepper u_dut (
      .clk(clk), .rst_n(rst_n), .target_code(target_code), .strap_min_imp(strap_min_imp),
      .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .desel_cycle(desel_cycle), .oe_off(oe_off),
      .drive_code(drive_code), .calibrated(calibrated)
   );

   int n_cmp = 0, n_bad = 0;
   int m_code = 32, m_pend = 0, m_tcnt = 0, m_warm = 0;
   bit finished = 0;

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // one clock: inputs already set; update model at edge, compare at next negedge
   task automatic step(string tag);
      int dir;
      bit tick, hz;
      @(posedge clk);
      if (strap_min_imp) begin
         m_code = 63;
         m_pend = 0;
      end else begin
         tick = (m_tcnt == PER - 1);
         if (tick) dir = (int'(target_code) > m_code) ? 1 : (int'(target_code) < m_code) ? -1 : 0;
         else      dir = m_pend;
         hz = wr_cycle || desel_cycle || oe_off;
         if (hz && dir != 0) begin
            m_code = m_code + dir;
            if (m_code > 63) m_code = 63;
            if (m_code < 0)  m_code = 0;
            m_pend = 0;
         end else if (tick) m_pend = dir;
      end
      m_tcnt = (m_tcnt + 1) % PER;
      if (!rd_cycle && m_warm < WARM) m_warm++;
      @(negedge clk);
      check(tag, int'(drive_code), m_code);
      if (m_warm < WARM) check("R6", int'(calibrated), 0);
      else check("R7", int'(calibrated),
                 (m_code == int'(target_code) && !strap_min_imp) ? 1 : 0);
   endtask

   task automatic set_ctl(bit rd, bit wr, bit ds, bit oe);
      rd_cycle = rd; wr_cycle = wr; desel_cycle = ds; oe_off = oe;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(drive_code), 32);
      check("R1", int'(calibrated), 0);
      rst_n = 1'b1;

      // R2/R3: all writes, target above: one step per 32 edges
      target_code = 6'd40;
      set_ctl(0, 1, 0, 0);
      for (int i = 0; i < 31; i++) step("R2");
      check("R2", int'(drive_code), 32);   // no step before the 32nd edge
      step("R2");
      check("R2", int'(drive_code), 33);   // first evaluation on edge 32
      for (int i = 0; i < 8 * PER; i++) step("R3");
      check("R3", int'(drive_code), 40);

      // R5: long read burst across several evaluations, then one deselect
      target_code = 6'd30;
      set_ctl(1, 0, 0, 0);
      for (int i = 0; i < 3 * PER + 5; i++) step("R5");
      check("R4", int'(drive_code), 40);
      set_ctl(0, 0, 1, 0);
      step("R5");
      check("R5", int'(drive_code), 39);   // single step, no stacking
      set_ctl(1, 0, 0, 1);                 // read with outputs disabled counts as hi-Z
      for (int i = 0; i < 4 * PER; i++) step("R4");

      // mixed traffic with changing targets
      for (int i = 0; i < 4000; i++) begin
         if (i % 500 == 0) target_code = W'($urandom_range(0, 63));
         set_ctl($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0);
         step("R5");
      end

      // R9: target at top, settle and hold without wrap
      target_code = 6'd63;
      set_ctl(0, 0, 1, 0);
      for (int i = 0; i < 70 * PER; i++) step("R9");
      check("R9", int'(drive_code), 63);
      check("R7", int'(calibrated), 1);

      // R8: strap forces min-impedance code, pending cleared
      target_code = 6'd20;
      set_ctl(1, 0, 0, 0);
      for (int i = 0; i < PER + 3; i++) step("R8");
      strap_min_imp = 1'b1;
      for (int i = 0; i < 2 * PER; i++) step("R8");
      check("R8", int'(drive_code), 63);
      check("R8", int'(calibrated), 0);
      strap_min_imp = 1'b0;
      set_ctl(0, 1, 0, 0);
      for (int i = 0; i < 3 * PER; i++) step("R8");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule